// File: doc/BRIEF.md
# Preset Frequency Hopping Controller

This block keeps a bank of eight 32-bit carrier frequency presets and a few configuration fields for a synthesizer front end. A host writes and reads them one byte at a time through a flat byte-addressed register port. Nothing a host writes reaches the synthesizer at once. All changes stay staged until the hop-list length register (address 35) is written. That write commits every staged field at once.

After a commit the block drives one preset's frequency word to the synthesizer, together with a step-size code and a reference-select bit. The active preset is the manual index in the committed configuration. An external hop strobe can then step through presets 0 to N-1 in a ring, where N is the committed list length. The strobe is asynchronous, so it is synchronized and edge-detected first. Each commit and each hop raises a load pulse for one cycle. The synthesizer takes the output word on that pulse.

Top module: `hop_preset_ctrl`

## Requirements
- R1: Preset 0 occupies byte addresses 0..3. Preset k (k = 1..7) occupies addresses 7+4(k-1) .. 10+4(k-1). Within a preset, the lowest address holds bits 7:0 and the highest holds bits 31:24.
- R2: Reads return the staged contents combinationally.
  - Address 4 uses only bit 0, the reference select.
  - Address 6 uses only these fields: bit 1 (strobe enable), bits 4:3 (step code) and bits 7:5 (manual index).
  - Address 35 returns the full 8-bit value written.
  - Address 36 returns the lock input in bit 0.
  - Unused bits and unused addresses read as 0.
- R3: A write to any address other than 35 changes neither freqWord, stepCode, refExternal nor loadPulse.
- R4: A write to address 35 raises loadPulse for exactly one cycle, in the cycle after the write edge. In that cycle freqWord holds the committed copy of the selected preset.
- R5: On commit, the pointer takes the staged manual index when that index is below the committed length. Otherwise the pointer becomes 0.
- R6: A committed length of 0 acts as 1. A committed length above 8 acts as 8.
- R7: When the committed strobe enable is 1, each strobe rising edge advances the pointer. The pointer counts 0, 1, .., N-1 and then returns to 0. The hop raises loadPulse on the third clock edge after the input rises, and the new word appears in that same cycle.
- R8: When the committed strobe enable is 0, strobe edges cause neither a pulse nor a pointer change.
- R9: A strobe held high for many cycles causes exactly one advance.
- R10: stepCode and refExternal show the step and reference fields that were staged at the last commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regAddr |
| hopStrobeIn | input | 1 | Asynchronous hop strobe |
| pllLocked | input | 1 | Lock flag from the synthesizer |
| freqWord | output | 32 | Selected frequency word |
| stepCode | output | 2 | Committed step-size code |
| refExternal | output | 1 | Committed reference select |
| loadPulse | output | 1 | One-cycle load strobe |

## Verification
The assertions check several rules on every cycle:
- the pointer always stays below the committed length;
- a hop lasts one cycle, and the pointer wraps to 0 after N-1;
- a disabled strobe leaves the pointer alone;
- step and reference outputs hold between commits;
- every commit is followed by a load pulse.

Only the directed scenarios can show the following:
- the byte placement of each preset and the read masking;
- the clamp of out-of-range lengths and indices;
- the three-edge strobe latency;
- that a long strobe gives one hop.

// File: rtl/hop_pkg.sv
package hop_pkg;
  localparam int NUM_PRESETS = 8;
  localparam int FREQ_W      = 32;
  localparam int ADDR_W      = 6;
  localparam int PTR_W       = $clog2(NUM_PRESETS);
  localparam int LEN_W       = PTR_W + 1;
  localparam int BYTES_PER   = FREQ_W / 8;

  localparam logic [ADDR_W-1:0] REF_ADDR   = 6'd4;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 6'd6;
  localparam logic [ADDR_W-1:0] LEN_ADDR   = 6'd35;
  localparam logic [ADDR_W-1:0] STAT_ADDR  = 6'd36;
  localparam int FIRST_HIGH = 7;

  typedef struct packed {
    logic             commit;
    logic [PTR_W-1:0] ptr;
  } ctlStrobe_t;

  typedef struct packed {
    logic [PTR_W-1:0] stagedIdx;
    logic [LEN_W-1:0] liveLen;
    logic             liveStrobeEn;
  } cfgView_t;

  function automatic logic [ADDR_W-1:0] presetAddr(input int k, input int b);
    if (k == 0) return ADDR_W'(b);
    return ADDR_W'(FIRST_HIGH + BYTES_PER * (k - 1) + b);
  endfunction

  function automatic logic [LEN_W-1:0] clampLen(input logic [7:0] v);
    if (v == 8'd0) return LEN_W'(1);
    if (v > 8'(NUM_PRESETS)) return LEN_W'(NUM_PRESETS);
    return v[LEN_W-1:0];
  endfunction
endpackage

// File: rtl/hop_datapath.sv
module hop_datapath
  import hop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  input  logic              pllLocked,
  input  ctlStrobe_t        ctl,
  output cfgView_t          cfg,
  output logic [7:0]        rdData,
  output logic [FREQ_W-1:0] freqWord,
  output logic [1:0]        stepCode,
  output logic              refExternal
);
  logic [FREQ_W-1:0] stagedFreq [NUM_PRESETS];
  logic [FREQ_W-1:0] liveFreq   [NUM_PRESETS];
  logic              stagedRef;
  logic              stagedStrobeEn;
  logic [1:0]        stagedStep;
  logic [PTR_W-1:0]  stagedIdx;
  logic [7:0]        stagedLen;
  logic              liveStrobeEn;
  logic [LEN_W-1:0]  liveLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_PRESETS; k++) stagedFreq[k] <= '0;
      stagedRef      <= 1'b0;
      stagedStrobeEn <= 1'b0;
      stagedStep     <= 2'b00;
      stagedIdx      <= '0;
      stagedLen      <= 8'd1;
    end else if (wrEn) begin
      for (int k = 0; k < NUM_PRESETS; k++)
        for (int b = 0; b < BYTES_PER; b++)
          if (regAddr == presetAddr(k, b)) stagedFreq[k][8*b +: 8] <= wrData;
      if (regAddr == REF_ADDR) stagedRef <= wrData[0];
      if (regAddr == CTRL_ADDR) begin
        stagedStrobeEn <= wrData[1];
        stagedStep     <= wrData[4:3];
        stagedIdx      <= wrData[7:5];
      end
      if (regAddr == LEN_ADDR) stagedLen <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_PRESETS; k++) liveFreq[k] <= '0;
      refExternal  <= 1'b0;
      stepCode     <= 2'b00;
      liveStrobeEn <= 1'b0;
      liveLen      <= LEN_W'(1);
    end else if (ctl.commit) begin
      for (int k = 0; k < NUM_PRESETS; k++) liveFreq[k] <= stagedFreq[k];
      refExternal  <= stagedRef;
      stepCode     <= stagedStep;
      liveStrobeEn <= stagedStrobeEn;
      liveLen      <= clampLen(wrData);
    end
  end

  always_comb begin
    rdData = 8'h00;
    for (int k = 0; k < NUM_PRESETS; k++)
      for (int b = 0; b < BYTES_PER; b++)
        if (regAddr == presetAddr(k, b)) rdData = stagedFreq[k][8*b +: 8];
    if (regAddr == REF_ADDR)  rdData = {7'b0, stagedRef};
    if (regAddr == CTRL_ADDR) rdData = {stagedIdx, stagedStep, 1'b0, stagedStrobeEn, 1'b0};
    if (regAddr == LEN_ADDR)  rdData = stagedLen;
    if (regAddr == STAT_ADDR) rdData = {7'b0, pllLocked};
  end

  assign freqWord = liveFreq[ctl.ptr];
  assign cfg = '{stagedIdx: stagedIdx, liveLen: liveLen, liveStrobeEn: liveStrobeEn};

  // Step and reference outputs move only on a commit.
  p_outputs_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> ($stable(stepCode) && $stable(refExternal)));
  // After a commit the committed length is always between 1 and 8.
  p_len_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> (liveLen >= LEN_W'(1) && liveLen <= LEN_W'(NUM_PRESETS)));
endmodule

// File: rtl/hop_control.sv
module hop_control
  import hop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  input  logic              hopStrobeIn,
  input  cfgView_t          cfg,
  output ctlStrobe_t        ctl,
  output logic              loadPulse
);
  logic             syncA, syncB, syncPrev;
  logic             strobeRise, commit, advance;
  logic [PTR_W-1:0] ptr;
  logic [LEN_W-1:0] newLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) {syncA, syncB, syncPrev} <= 3'b000;
    else       {syncA, syncB, syncPrev} <= {hopStrobeIn, syncA, syncB};
  end

  assign strobeRise = syncB & ~syncPrev;
  assign commit     = wrEn && (regAddr == LEN_ADDR);
  assign advance    = strobeRise && cfg.liveStrobeEn && !commit;
  assign newLen     = clampLen(wrData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      loadPulse <= 1'b0;
    end else begin
      loadPulse <= commit | advance;
      if (commit)
        ptr <= ({1'b0, cfg.stagedIdx} < newLen) ? cfg.stagedIdx : '0;
      else if (advance)
        ptr <= ({1'b0, ptr} == cfg.liveLen - LEN_W'(1)) ? '0 : ptr + PTR_W'(1);
    end
  end

  assign ctl = '{commit: commit, ptr: ptr};

  p_ptr_in_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, ptr} < cfg.liveLen));
  p_commit_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> loadPulse);
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (advance && ({1'b0, ptr} == cfg.liveLen - LEN_W'(1))) |=> (ptr == '0));
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.liveStrobeEn && !commit) |=> ($stable(ptr) && !loadPulse));
  p_single_hop_r9: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> !advance);
endmodule

// File: rtl/hop_preset_ctrl.sv
module hop_preset_ctrl
  import hop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              hopStrobeIn,
  input  logic              pllLocked,
  output logic [FREQ_W-1:0] freqWord,
  output logic [1:0]        stepCode,
  output logic              refExternal,
  output logic              loadPulse
);
  ctlStrobe_t ctl;
  cfgView_t   cfg;

  hop_control u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .hopStrobeIn(hopStrobeIn), .cfg(cfg), .ctl(ctl), .loadPulse(loadPulse)
  );

  hop_datapath u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .pllLocked(pllLocked), .ctl(ctl), .cfg(cfg), .rdData(rdData),
    .freqWord(freqWord), .stepCode(stepCode), .refExternal(refExternal)
  );
endmodule

// File: tb/sim_hop_preset_ctrl.sv
module sim_hop_preset_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        hopStrobeIn = 1'b0;
  logic        pllLocked = 1'b0;
  logic [31:0] freqWord;
  logic [1:0]  stepCode;
  logic        refExternal;
  logic        loadPulse;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hop_preset_ctrl u0 (.*);

  function automatic logic [31:0] presetVal(input int k);
    return 32'h1A2B3C40 + 32'h01020304 * k;
  endfunction

  function automatic int addrOf(input int k, input int b);
    return (k == 0) ? b : 7 + 4 * (k - 1) + b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input int a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = 6'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input int a, input logic [7:0] exp);
    @(negedge clk);
    regAddr = 6'(a);
    #1 check(req, {24'b0, rdData}, {24'b0, exp});
  endtask

  // ctrl byte: idx in 7:5, step in 4:3, enable in bit 1
  function automatic logic [7:0] ctrlByte(input int idx, input int step, input bit en);
    return {3'(idx), 2'(step), 1'b0, en, 1'b0};
  endfunction

  task automatic commitCheck(input string req, input logic [7:0] len, input int expK);
    writeReg(35, len);
    check({req, " pulse"}, {31'b0, loadPulse}, 32'd1);
    check({req, " word"}, freqWord, presetVal(expK));
    @(negedge clk);
    check({req, " pulse drop"}, {31'b0, loadPulse}, 32'd0);
  endtask

  task automatic hopCheck(input string req, input int expK);
    @(negedge clk); hopStrobeIn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({req, " hop pulse"}, {31'b0, loadPulse}, 32'd1);
    check({req, " hop word"}, freqWord, presetVal(expK));
    hopStrobeIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R4 reset pulse", {31'b0, loadPulse}, 32'd0);
    check("R4 reset word", freqWord, 32'd0);
    check("R10 reset step", {30'b0, stepCode}, 32'd0);
    check("R10 reset ref", {31'b0, refExternal}, 32'd0);
  endtask

  task automatic t_regs;
    for (int k = 0; k < 8; k++)
      for (int b = 0; b < 4; b++) writeReg(addrOf(k, b), presetVal(k)[8*b +: 8]);
    readCheck("R1 p0 lsb", 0, presetVal(0)[7:0]);
    readCheck("R1 p1 lsb", 7, presetVal(1)[7:0]);
    readCheck("R1 p3 msb", 18, presetVal(3)[31:24]);
    readCheck("R1 p7 msb", 34, presetVal(7)[31:24]);
    writeReg(4, 8'hFF);  readCheck("R2 ref mask", 4, 8'h01);
    writeReg(6, 8'hFF);  readCheck("R2 ctrl mask", 6, 8'hFA);
    writeReg(5, 8'hFF);  readCheck("R2 unused addr", 5, 8'h00);
    readCheck("R2 high addr", 50, 8'h00);
    pllLocked = 1'b1;    readCheck("R2 lock set", 36, 8'h01);
    pllLocked = 1'b0;    readCheck("R2 lock clr", 36, 8'h00);
    writeReg(35, 8'hC8); readCheck("R2 len raw", 35, 8'hC8);
  endtask

  task automatic t_staged;
    writeReg(35, 8'd8);
    writeReg(4, 8'h00);
    writeReg(6, ctrlByte(2, 0, 0));
    writeReg(35, 8'd8);
    check("R10 ref low", {31'b0, refExternal}, 32'd0);
    writeReg(4, 8'h01);
    writeReg(6, ctrlByte(4, 2, 0));
    writeReg(addrOf(2, 0), 8'h99);
    check("R3 pulse none", {31'b0, loadPulse}, 32'd0);
    check("R3 word held", freqWord, presetVal(2));
    check("R3 step held", {30'b0, stepCode}, 32'd0);
    check("R3 ref held", {31'b0, refExternal}, 32'd0);
    writeReg(addrOf(2, 0), presetVal(2)[7:0]);
    commitCheck("R4 R5 commit idx4", 8'd8, 4);
    check("R10 step", {30'b0, stepCode}, 32'd2);
    check("R10 ref", {31'b0, refExternal}, 32'd1);
  endtask

  task automatic t_clamp;
    writeReg(6, ctrlByte(5, 1, 1));
    commitCheck("R5 idx beyond len", 8'd3, 0);
    commitCheck("R6 len zero", 8'd0, 0);
    hopCheck("R6 len zero ring", 0);
    writeReg(6, ctrlByte(7, 1, 1));
    commitCheck("R6 len large", 8'd200, 7);
    hopCheck("R6 len large wrap", 0);
  endtask

  task automatic t_hop;
    writeReg(6, ctrlByte(0, 0, 1));
    commitCheck("R7 start", 8'd3, 0);
    hopCheck("R7 hop1", 1);
    hopCheck("R7 hop2", 2);
    hopCheck("R7 wrap", 0);
    hopCheck("R7 again", 1);
  endtask

  task automatic t_disabled;
    writeReg(6, ctrlByte(1, 0, 0));
    commitCheck("R8 start", 8'd4, 1);
    @(negedge clk); hopStrobeIn = 1'b1;
    repeat (6) begin
      @(negedge clk);
      check("R8 no pulse", {31'b0, loadPulse}, 32'd0);
    end
    hopStrobeIn = 1'b0;
    check("R8 word kept", freqWord, presetVal(1));
  endtask

  task automatic t_held;
    int pulses = 0;
    writeReg(6, ctrlByte(0, 0, 1));
    commitCheck("R9 start", 8'd8, 0);
    @(negedge clk); hopStrobeIn = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (loadPulse) pulses++;
    end
    hopStrobeIn = 1'b0;
    check("R9 one hop", 32'(pulses), 32'd1);
    check("R9 word", freqWord, presetVal(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_staged();
    t_clamp();
    t_hop();
    t_disabled();
    t_held();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule